// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves a WIDTH-bit word between two buses, A and B, in either direction. Each bus has its own capture register. Whichever bus is driven can carry either the live value on the other bus or that other bus's captured copy. Each pad is split into an input, an output and an output-enable, so the block contains no tristate nets. A build-time parameter selects whether the driven word is passed through unchanged or inverted bit by bit.

The A register is clocked by its own clock, `clk_ab`, and the B register by `clk_ba`. A capture happens on every rising edge of a register's clock, whatever the output controls are doing. This means a word can be stored while the outputs are isolated, and the undriven bus can be stored while the other bus is being driven. Reset is synchronous and active high, and each register samples it in its own clock domain.

Top module: `reg_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab` the A register loads `a_in`. On each rising edge of `clk_ba` the B register loads `b_in`. Without an edge, each register keeps its value.
- R2: Captures do not depend on `oe_n` and `dir`. They take place during isolation, and they take place on a bus while the opposite bus is being driven.
- R3: When `rst` is high at a rising edge of a register's clock, that register clears to zero. The other register is left unchanged unless its own clock also rises.
- R4: When `oe_n` = 1 (isolation), `a_oe` = 0 and `b_oe` = 0, and both stored words are kept unless their clocks rise.
- R5: When `oe_n` = 0 and `dir` = 0, `a_oe` = 1 and `b_oe` = 0. When `oe_n` = 0 and `dir` = 1, `b_oe` = 1 and `a_oe` = 0. The two enables are never high together.
- R6: While A is driven, `a_out` is derived from the live `b_in` when `sel_ba` = 0 and from the B register when `sel_ba` = 1.
- R7: While B is driven, `b_out` is derived from the live `a_in` when `sel_ab` = 0 and from the A register when `sel_ab` = 1.
- R8: With `INVERT` = 0 the driven output equals the selected word. With `INVERT` = 1 it equals the bitwise complement of the selected word.
- R9: The output of an undriven side is all zeros.
- R10: The output path is purely combinational. A change on a data input, a select, `oe_n` or `dir` reaches the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock for the A register |
| clk_ba | input | 1 | Capture clock for the B register |
| rst | input | 1 | Synchronous active-high reset, sampled in each clock domain |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | Direction: 0 drives A, 1 drives B |
| sel_ab | input | 1 | B-side source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A-side source: 0 live B, 1 stored B |
| a_in | input | WIDTH | Value seen on the A pads |
| a_out | output | WIDTH | Value driven onto the A pads |
| a_oe | output | 1 | A pad driver enable |
| b_in | input | WIDTH | Value seen on the B pads |
| b_out | output | WIDTH | Value driven onto the B pads |
| b_oe | output | 1 | B pad driver enable |

## Verification
Two functions can fall in the same cycle: a capture on one bus, and driving the opposite bus from stored or live data. The bench provokes this by pulsing `clk_ab` while B is driven, and both clocks while the outputs are isolated. It then checks that the driven output still follows the old selection until the new stored value is requested. A single clock pulse under reset is also checked to clear only its own register. Every combination of `oe_n`, `dir` and the two selects is compared with a reference model. The comparison runs for several data patterns, on one true instance and one inverting instance at the same time.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XV_DEFAULT_WIDTH = 8;

    typedef enum logic [1:0] {
        XV_ISOLATE = 2'd0,
        XV_DRIVE_A = 2'd1,
        XV_DRIVE_B = 2'd2
    } xv_mode_e;

    typedef struct packed {
        logic oe_n;
        logic dir;
        logic sel_ab;
        logic sel_ba;
    } xv_ctrl_t;

    function automatic xv_mode_e xv_decode(input xv_ctrl_t c);
        if (c.oe_n)
            return XV_ISOLATE;
        else if (c.dir)
            return XV_DRIVE_B;
        else
            return XV_DRIVE_A;
    endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int WIDTH = xcvr_pkg::XV_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

    // R1: each edge out of reset leaves the word seen at that edge
    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> q == $past(d))
        else $error("capture mismatch");

endmodule

// File: rtl/xcvr_dir_ctl.sv
module xcvr_dir_ctl
    import xcvr_pkg::*;
(
    input  xv_ctrl_t ctrl,
    output xv_mode_e mode,
    output logic     a_en,
    output logic     b_en
);

    always_comb begin
        mode = xv_decode(ctrl);
        a_en = (mode == XV_DRIVE_A);
        b_en = (mode == XV_DRIVE_B);
    end

endmodule

// File: rtl/xcvr_out_path.sv
module xcvr_out_path #(
    parameter int WIDTH  = xcvr_pkg::XV_DEFAULT_WIDTH,
    parameter bit INVERT = 1'b0
) (
    input  logic             en,
    input  logic             sel,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] out
);

    logic [WIDTH-1:0] chosen;
    logic [WIDTH-1:0] shaped;

    // single-level select between live and stored word
    assign chosen = sel ? stored : live;

    generate
        if (INVERT) begin : g_inv
            assign shaped = ~chosen;
        end else begin : g_true
            assign shaped = chosen;
        end
    endgenerate

    assign out = en ? shaped : '0;

endmodule

// File: rtl/reg_xcvr.sv
module reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH  = XV_DEFAULT_WIDTH,
    parameter bit INVERT = 1'b0
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    xv_ctrl_t         ctrl;
    xv_mode_e         mode;
    logic [WIDTH-1:0] a_store;
    logic [WIDTH-1:0] b_store;

    assign ctrl = '{oe_n: oe_n, dir: dir, sel_ab: sel_ab, sel_ba: sel_ba};

    xcvr_store_reg #(.WIDTH(WIDTH)) a_reg_i (
        .clk (clk_ab),
        .rst (rst),
        .d   (a_in),
        .q   (a_store)
    );

    xcvr_store_reg #(.WIDTH(WIDTH)) b_reg_i (
        .clk (clk_ba),
        .rst (rst),
        .d   (b_in),
        .q   (b_store)
    );

    xcvr_dir_ctl dir_i (
        .ctrl (ctrl),
        .mode (mode),
        .a_en (a_oe),
        .b_en (b_oe)
    );

    // A side is fed from the B bus or the B register
    xcvr_out_path #(.WIDTH(WIDTH), .INVERT(INVERT)) a_path_i (
        .en     (a_oe),
        .sel    (ctrl.sel_ba),
        .live   (b_in),
        .stored (b_store),
        .out    (a_out)
    );

    // B side is fed from the A bus or the A register
    xcvr_out_path #(.WIDTH(WIDTH), .INVERT(INVERT)) b_path_i (
        .en     (b_oe),
        .sel    (ctrl.sel_ab),
        .live   (a_in),
        .stored (a_store),
        .out    (b_out)
    );

    always_comb begin
        p_one_side_r5: assert (!(a_oe && b_oe))
            else $error("both buses driven");
        if (oe_n) begin
            p_isolate_r4: assert (!a_oe && !b_oe && mode == XV_ISOLATE)
                else $error("drive during isolation");
        end
        if (!a_oe) begin
            p_a_idle_r9: assert (a_out == '0)
                else $error("undriven A output not zero");
        end
        if (!b_oe) begin
            p_b_idle_r9: assert (b_out == '0)
                else $error("undriven B output not zero");
        end
    end

endmodule

// File: tb/reg_xcvr_tb_top.sv
module reg_xcvr_tb_top;

    localparam int W = 8;

    logic clk = 1'b0;
    logic en_ab = 1'b0, en_ba = 1'b0;
    logic clk_ab, clk_ba;
    logic rst = 1'b1;
    logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out_t, b_out_t, a_out_i, b_out_i;
    logic a_oe_t, b_oe_t, a_oe_i, b_oe_i;

    logic [W-1:0] ma = '0, mb = '0;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    assign clk_ab = clk & en_ab;
    assign clk_ba = clk & en_ba;

    reg_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out_t),
        .a_oe(a_oe_t), .b_in(b_in), .b_out(b_out_t), .b_oe(b_oe_t)
    );

    reg_xcvr #(.WIDTH(W), .INVERT(1'b1)) dut_inv_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out_i),
        .a_oe(a_oe_i), .b_in(b_in), .b_out(b_out_i), .b_oe(b_oe_i)
    );

    task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one rising edge on each requested capture clock; the model follows
    task automatic capture(input bit do_a, input bit do_b);
        @(negedge clk);
        en_ab = do_a;
        en_ba = do_b;
        @(negedge clk);
        en_ab = 1'b0;
        en_ba = 1'b0;
        if (do_a) ma = rst ? '0 : a_in;
        if (do_b) mb = rst ? '0 : b_in;
    endtask

    // full comparison of both instances against the model (R5 R6 R7 R8 R9)
    task automatic check_all(input string tag);
        logic ea, eb;
        logic [W-1:0] va, vb;
        #1;
        ea = !oe_n && !dir;
        eb = !oe_n && dir;
        va = sel_ba ? mb : b_in;
        vb = sel_ab ? ma : a_in;
        cmp({tag, " R5 a_oe"}, {7'd0, a_oe_t}, {7'd0, ea});
        cmp({tag, " R5 b_oe"}, {7'd0, b_oe_t}, {7'd0, eb});
        cmp({tag, " R5 a_oe inv"}, {7'd0, a_oe_i}, {7'd0, ea});
        cmp({tag, " R5 b_oe inv"}, {7'd0, b_oe_i}, {7'd0, eb});
        cmp({tag, " R6 R9 a_out"}, a_out_t, ea ? va : '0);
        cmp({tag, " R7 R9 b_out"}, b_out_t, eb ? vb : '0);
        cmp({tag, " R8 a_out inv"}, a_out_i, ea ? ~va : '0);
        cmp({tag, " R8 b_out inv"}, b_out_i, eb ? ~vb : '0);
    endtask

    task automatic set_ctrl(input logic [3:0] c);
        oe_n = c[3]; dir = c[2]; sel_ab = c[1]; sel_ba = c[0];
    endtask

    initial begin
        // R3: reset clears both registers
        a_in = 8'hA5; b_in = 8'h3C;
        capture(1'b1, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        set_ctrl(4'b0001);      // drive A from B register
        check_all("reset R3");
        set_ctrl(4'b0110);      // drive B from A register
        check_all("reset R3");

        // R2 R4: capture while isolated
        set_ctrl(4'b1011);
        a_in = 8'h5A; b_in = 8'hC3;
        capture(1'b1, 1'b1);
        check_all("isolated capture R2");

        // R10 sweep: all control combos over several live patterns, no clock
        for (int p = 0; p < 8; p++) begin
            a_in = 8'(p * 37 + 5);
            b_in = 8'(p * 91 + 200);
            for (int c = 0; c < 16; c++) begin
                set_ctrl(4'(c));
                check_all("sweep R10");
            end
        end

        // R2: capture A while B is driven from stored A; output changes after edge
        set_ctrl(4'b0110);
        a_in = 8'h71;
        check_all("before capture R7");
        capture(1'b1, 1'b0);
        check_all("capture while driving R2");
        cmp("R1 stored A", b_out_t, 8'h71);

        // R2: capture B while A is driven live, then show stored B
        set_ctrl(4'b0000);
        b_in = 8'h9E;
        capture(1'b0, 1'b1);
        b_in = 8'h11;
        set_ctrl(4'b0001);
        check_all("capture undriven R2");
        cmp("R1 stored B", a_out_t, 8'h9E);

        // R4: isolation holds stored words while inputs move, no clocks
        set_ctrl(4'b1011);
        a_in = 8'hFF; b_in = 8'h00;
        repeat (3) @(negedge clk);
        set_ctrl(4'b0110);
        check_all("hold R4");
        cmp("R4 hold A", b_out_t, 8'h71);
        set_ctrl(4'b0001);
        check_all("hold R4");
        cmp("R4 hold B", a_out_t, 8'h9E);

        // R3: reset with only clk_ab rising clears A alone
        rst = 1'b1;
        capture(1'b1, 1'b0);
        rst = 1'b0;
        set_ctrl(4'b0110);
        check_all("domain reset R3");
        cmp("R3 A cleared", b_out_t, 8'h00);
        set_ctrl(4'b0001);
        check_all("domain reset R3");
        cmp("R3 B kept", a_out_t, 8'h9E);

        // R1: fresh captures with both clocks after reset, stored sweep
        for (int p = 0; p < 4; p++) begin
            a_in = 8'(p * 53 + 17);
            b_in = 8'(p * 29 + 128);
            capture(1'b1, 1'b1);
            a_in = ~a_in;
            b_in = ~b_in;
            for (int c = 0; c < 16; c++) begin
                set_ctrl(4'(c));
                check_all("stored sweep R1");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule